// File: doc/BRIEF.md
# Power-Down Entry and Wake Controller

This block sequences a chip into and out of its deepest sleep state. Software programs a 9-bit control word that holds the oscillator enables, the wake options and a power-down request bit. Once the request is set, the block removes the system clock at once, or, if the wait-for-CPU option is chosen, only after the processor reports that it is sleeping. While powered down, the crystal enable, the fast internal oscillator enable, the PLL enable and the system clock enable are all forced low. The slow oscillator keeps following its own control bit.

A wake event on any wake input (by default bit 0 is a GPIO wake and bit 1 is a UART wake) ends power-down. The request bit then clears itself. If the delay option is set, the system clock stays off until a number of ticks of the active source have been counted: 4096 ticks when running from the crystal, or 256 ticks when running from the fast oscillator. A sticky wake flag and a level interrupt report the wake when the interrupt option is enabled.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After reset the control word reads 0x00C. The system clock, PLL and fast oscillator enables are 1. The crystal enable and the wake interrupt are 0.
- R2: When the wait-for-CPU bit (bit 8) is 0, writing 1 to the request bit (bit 7) leaves the system clock on for the cycle after the write. From the following cycle on, the system clock, PLL, crystal (bit 0) and fast oscillator (bit 2) enables are all 0.
- R3: When the wait-for-CPU bit is 1 and the request bit is set, the system clock stays on for as long as cpu_sleep is 0. It turns off on the cycle after cpu_sleep is sampled as 1.
- R4: If the delay bit (bit 4) is 0, a wake event restores all enables at the clock edge where the event is sampled. At that same edge the request bit reads back as 0.
- R5: If the delay bit is 1 and src_is_xtal is 1 when the wake is sampled, the oscillator and PLL enables return at once. The system clock returns exactly at the edge where the 4096th src_tick after the wake edge is counted.
- R6: If the delay bit is 1 and src_is_xtal is 0, the system clock returns at the edge where the 256th src_tick is counted. Cycles with src_tick low are not counted.
- R7: If the interrupt enable bit (bit 5) is 1, a wake sets the status bit (bit 6) and raises wake_irq. Both stay set until software writes 1 to bit 6. Writing 0 to bit 6 has no effect.
- R8: If the interrupt enable bit is 0, a wake leaves the status bit and wake_irq at 0.
- R9: Wake events that arrive while the block is not powered down have no effect on the clocks, on the status bit or on wake_irq.
- R10: slow_osc_en always equals the slow oscillator bit (bit 3), including during power-down.
- R11: A write updates bits 0, 2, 3, 4, 5, 7 and 8. Bit 1 always reads 0, and bit 6 can only be cleared by software.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 9 | Write data |
| reg_rdata | output | 9 | Current control word |
| cpu_sleep | input | 1 | Processor reports it is sleeping |
| wake_src | input | N_WAKE | Wake events (bit 0 GPIO, bit 1 UART) |
| src_is_xtal | input | 1 | Active clock source is the crystal |
| src_tick | input | 1 | One tick of the active clock source |
| xtal_en | output | 1 | Crystal oscillator enable |
| fast_osc_en | output | 1 | Fast internal oscillator enable |
| slow_osc_en | output | 1 | Slow internal oscillator enable |
| pll_en | output | 1 | PLL enable |
| sysclk_en | output | 1 | System clock enable |
| wake_irq | output | 1 | Wake interrupt, level |

## Verification
The hardest case to reach is the end of the wake delay. Here the system clock must return on the exact edge that counts the last source tick, and the ticks arrive irregularly. To reach it, the bench first powers the block down with the delay bit set. It then fires a wake event and drives src_tick from a seeded random stream, counting the ticks itself. After every edge it compares sysclk_en with the result of that count. The wait-for-CPU path is reached by holding cpu_sleep low for many cycles with the request pending, and only then raising it.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
   localparam int CTRL_W = 9;

   localparam int B_XTAL   = 0;
   localparam int B_FAST   = 2;
   localparam int B_SLOW   = 3;
   localparam int B_DLY    = 4;
   localparam int B_IRQEN  = 5;
   localparam int B_STAT   = 6;
   localparam int B_PDREQ  = 7;
   localparam int B_WAITC  = 8;

   localparam logic [CTRL_W-1:0] WR_MASK = 9'h1BD;

   typedef enum logic [1:0] {
      ST_RUN      = 2'd0,
      ST_WAIT_CPU = 2'd1,
      ST_PD       = 2'd2,
      ST_WAKE_DLY = 2'd3
   } pd_state_e;
endpackage

// File: rtl/pwrdn_wake_in.sv
module pwrdn_wake_in #(
   parameter int N_WAKE      = 2,
   parameter int SYNC_STAGES = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_WAKE-1:0] wake_src,
   output logic              wake_any
);
   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign wake_any = |wake_src;
      end else begin : g_sync
         logic [N_WAKE-1:0] stage_q [SYNC_STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
            end else begin
               stage_q[0] <= wake_src;
               for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
            end
         end
         assign wake_any = |stage_q[SYNC_STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/pwrdn_regs.sv
module pwrdn_regs
   import pwrdn_pkg::*;
#(
   parameter logic [CTRL_W-1:0] RST_VAL = 9'h00C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CTRL_W-1:0] wdata,
   input  logic              wake_hit,
   output logic [CTRL_W-1:0] ctrl
);
   logic [CTRL_W-1:0] ctrl_q, ctrl_d;

   always_comb begin
      ctrl_d = ctrl_q;
      if (wr) begin
         ctrl_d = (ctrl_q & ~WR_MASK) | (wdata & WR_MASK);
         if (wdata[B_STAT]) ctrl_d[B_STAT] = 1'b0;
      end
      if (wake_hit) begin
         ctrl_d[B_PDREQ] = 1'b0;
         if (ctrl_q[B_IRQEN]) ctrl_d[B_STAT] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= RST_VAL & WR_MASK;
      else        ctrl_q <= ctrl_d;
   end

   assign ctrl = ctrl_q;
endmodule

// File: rtl/pwrdn_fsm.sv
module pwrdn_fsm
   import pwrdn_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pd_req,
   input  logic      wait_cpu,
   input  logic      cpu_sleep,
   input  logic      wake,
   input  logic      dly_en,
   input  logic      dly_done,
   output pd_state_e state,
   output logic      wake_hit
);
   pd_state_e state_q, state_d;

   assign wake_hit = (state_q == ST_PD) && wake;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_RUN: begin
            if (pd_req) begin
               if (!wait_cpu || cpu_sleep) state_d = ST_PD;
               else                        state_d = ST_WAIT_CPU;
            end
         end
         ST_WAIT_CPU: begin
            if (!pd_req)                     state_d = ST_RUN;
            else if (!wait_cpu || cpu_sleep) state_d = ST_PD;
         end
         ST_PD: begin
            if (wake) state_d = dly_en ? ST_WAKE_DLY : ST_RUN;
         end
         ST_WAKE_DLY: begin
            if (dly_done) state_d = ST_RUN;
         end
         default: state_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_RUN;
      else        state_q <= state_d;
   end

   assign state = state_q;
endmodule

// File: rtl/pwrdn_wake_timer.sv
module pwrdn_wake_timer #(
   parameter int XTAL_WAIT = 4096,
   parameter int FAST_WAIT = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic use_xtal,
   input  logic active,
   input  logic tick,
   output logic done
);
   localparam int MAX_WAIT = (XTAL_WAIT > FAST_WAIT) ? XTAL_WAIT : FAST_WAIT;
   localparam int CNT_W    = $clog2(MAX_WAIT);
   localparam logic [CNT_W-1:0] XTAL_LAST = CNT_W'(XTAL_WAIT - 1);
   localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_WAIT - 1);

   logic [CNT_W-1:0] cnt_q, last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         last_q <= FAST_LAST;
      end else if (start) begin
         cnt_q  <= '0;
         last_q <= use_xtal ? XTAL_LAST : FAST_LAST;
      end else if (active && tick) begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign done = active && tick && (cnt_q == last_q);
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
   import pwrdn_pkg::*;
#(
   parameter int                N_WAKE      = 2,
   parameter int                SYNC_STAGES = 0,
   parameter int                XTAL_WAIT   = 4096,
   parameter int                FAST_WAIT   = 256,
   parameter logic [CTRL_W-1:0] RST_VAL     = 9'h00C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [CTRL_W-1:0] reg_wdata,
   output logic [CTRL_W-1:0] reg_rdata,
   input  logic              cpu_sleep,
   input  logic [N_WAKE-1:0] wake_src,
   input  logic              src_is_xtal,
   input  logic              src_tick,
   output logic              xtal_en,
   output logic              fast_osc_en,
   output logic              slow_osc_en,
   output logic              pll_en,
   output logic              sysclk_en,
   output logic              wake_irq
);
   generate
      if (N_WAKE < 1) begin : g_bad_nwake
         $error("N_WAKE must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
      if (XTAL_WAIT < 2 || FAST_WAIT < 2) begin : g_bad_wait
         $error("wake wait lengths must be at least 2");
      end
   endgenerate

   logic [CTRL_W-1:0] ctrl;
   logic              wake_any, wake_hit, dly_done, powered;
   pd_state_e         state;

   pwrdn_wake_in #(.N_WAKE(N_WAKE), .SYNC_STAGES(SYNC_STAGES)) u_wake (
      .clk(clk), .rst_n(rst_n), .wake_src(wake_src), .wake_any(wake_any)
   );

   pwrdn_regs #(.RST_VAL(RST_VAL)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata),
      .wake_hit(wake_hit), .ctrl(ctrl)
   );

   pwrdn_fsm u_fsm (
      .clk(clk), .rst_n(rst_n),
      .pd_req(ctrl[B_PDREQ]), .wait_cpu(ctrl[B_WAITC]), .cpu_sleep(cpu_sleep),
      .wake(wake_any), .dly_en(ctrl[B_DLY]), .dly_done(dly_done),
      .state(state), .wake_hit(wake_hit)
   );

   pwrdn_wake_timer #(.XTAL_WAIT(XTAL_WAIT), .FAST_WAIT(FAST_WAIT)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .start(wake_hit && ctrl[B_DLY]), .use_xtal(src_is_xtal),
      .active(state == ST_WAKE_DLY), .tick(src_tick), .done(dly_done)
   );

   assign powered     = (state != ST_PD);
   assign sysclk_en   = (state == ST_RUN) || (state == ST_WAIT_CPU);
   assign pll_en      = powered;
   assign xtal_en     = powered && ctrl[B_XTAL];
   assign fast_osc_en = powered && ctrl[B_FAST];
   assign slow_osc_en = ctrl[B_SLOW];
   assign wake_irq    = ctrl[B_STAT] && ctrl[B_IRQEN];
   assign reg_rdata   = ctrl;
endmodule

// File: rtl/pwrdn_ctrl_chk.sv
module pwrdn_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [8:0] reg_rdata,
   input logic       cpu_sleep,
   input logic       xtal_en,
   input logic       fast_osc_en,
   input logic       pll_en,
   input logic       sysclk_en,
   input logic       wake_irq
);
   AST_PD_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !pll_en |-> (!sysclk_en && !xtal_en && !fast_osc_en)); // R2

   AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata[8] && reg_rdata[7] && !cpu_sleep && sysclk_en) |=> sysclk_en); // R3

   AST_REQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_en) |-> !reg_rdata[7]); // R4

   AST_IRQ_FROM_PD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_irq) |-> $past(!pll_en)); // R7

   AST_STAT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_rdata[6]) |-> $past(reg_rdata[5])); // R8
endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk u_pwrdn_chk (
   .clk(clk), .rst_n(rst_n), .reg_rdata(reg_rdata), .cpu_sleep(cpu_sleep),
   .xtal_en(xtal_en), .fast_osc_en(fast_osc_en), .pll_en(pll_en),
   .sysclk_en(sysclk_en), .wake_irq(wake_irq)
);

// File: tb/pwrdn_ctrl_bench.sv
module pwrdn_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [8:0] reg_wdata = '0;
   logic [8:0] reg_rdata;
   logic       cpu_sleep = 1'b0;
   logic [1:0] wake_src = '0;
   logic       src_is_xtal = 1'b0;
   logic       src_tick = 1'b0;
   logic       xtal_en, fast_osc_en, slow_osc_en, pll_en, sysclk_en, wake_irq;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   pwrdn_ctrl u_pwrdn_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .cpu_sleep(cpu_sleep), .wake_src(wake_src),
      .src_is_xtal(src_is_xtal), .src_tick(src_tick), .xtal_en(xtal_en),
      .fast_osc_en(fast_osc_en), .slow_osc_en(slow_osc_en), .pll_en(pll_en),
      .sysclk_en(sysclk_en), .wake_irq(wake_irq)
   );

   function automatic logic [8:0] model_write(input logic [8:0] old, input logic [8:0] d);
      logic [8:0] n;
      n = (old & ~9'h1BD) | (d & 9'h1BD);
      if (d[6]) n[6] = 1'b0;
      return n;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [8:0] d);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic wake_pulse(input int idx);
      @(negedge clk);
      wake_src[idx] = 1'b1;
      @(negedge clk);
      wake_src = '0;
   endtask

   task automatic delay_run(input string req, input int target, input bit rand_tick);
      int ticks = 0;
      int bad = 0;
      wake_pulse(0);
      chk(req, {pll_en, xtal_en, fast_osc_en, sysclk_en}, 4'b1110);
      while (ticks < target) begin
         src_tick = rand_tick ? 1'($urandom) : 1'b1;
         @(negedge clk);
         if (src_tick) ticks++;
         if (sysclk_en !== (ticks == target)) bad++;
      end
      src_tick = 1'b0;
      chk(req, bad, 0);
      chk(req, sysclk_en, 1'b1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [8:0] model;
      int seed_init;
      seed_init = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", reg_rdata, 9'h00C);
      chk("R1", {sysclk_en, pll_en, fast_osc_en, xtal_en, wake_irq}, 5'b11100);

      // R11 R9 R10 random writes with the request bit held low, stray wakes
      model = 9'h00C;
      for (int i = 0; i < 200; i++) begin
         logic [8:0] d;
         d = 9'($urandom) & 9'h17F;
         wr(d);
         model = model_write(model, d);
         if ($urandom % 3 == 0) wake_pulse(int'($urandom % 2));
         chk("R11", reg_rdata, model);
         chk("R9", {sysclk_en, wake_irq}, 2'b10);
         chk("R10", slow_osc_en, model[3]);
         chk("R11", {xtal_en, fast_osc_en}, {model[0], model[2]});
      end

      // R2 immediate entry
      wr(9'h00D);
      wr(9'h08D);
      chk("R2", sysclk_en, 1'b1);
      @(negedge clk);
      chk("R2", {sysclk_en, pll_en, xtal_en, fast_osc_en}, 4'b0000);
      chk("R10", slow_osc_en, 1'b1);
      repeat (5) @(negedge clk);
      chk("R2", sysclk_en, 1'b0);

      // R4 R8 wake without delay, interrupt disabled
      wake_pulse(0);
      chk("R4", {sysclk_en, pll_en, xtal_en, fast_osc_en}, 4'b1111);
      chk("R4", reg_rdata[7], 1'b0);
      chk("R8", {reg_rdata[6], wake_irq}, 2'b00);

      // R3 wait for CPU sleep
      wr(9'h1AD);
      repeat (20) @(negedge clk);
      chk("R3", sysclk_en, 1'b1);
      cpu_sleep = 1'b1;
      @(negedge clk);
      chk("R3", {sysclk_en, pll_en}, 2'b00);
      cpu_sleep = 1'b0;

      // R7 interrupt on UART wake, sticky until write-1
      wake_pulse(1);
      chk("R7", {sysclk_en, reg_rdata[6], wake_irq}, 3'b111);
      wr(9'h12D);
      chk("R7", {reg_rdata[6], wake_irq}, 2'b11);
      wr(9'h16D);
      chk("R7", {reg_rdata[6], wake_irq}, 2'b00);

      // R5 delay from crystal, slow oscillator off in power-down
      wr(9'h015);
      wr(9'h095);
      @(negedge clk);
      chk("R10", {slow_osc_en, pll_en}, 2'b00);
      src_is_xtal = 1'b1;
      delay_run("R5", 4096, 1'b0);

      // R6 delay from fast oscillator, irregular ticks
      wr(9'h09D);
      @(negedge clk);
      chk("R6", sysclk_en, 1'b0);
      src_is_xtal = 1'b0;
      delay_run("R6", 256, 1'b1);
      chk("R6", reg_rdata[7], 1'b0);

      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule